// File: doc/BRIEF.md
# Queue-Level Interrupt Status and Mask Controller

This block produces the interrupt status word and the single interrupt line for a serial flash controller that has three queues: a command queue, a receive queue and a transmit queue. Each cycle it takes the fill count of every queue and compares it against that queue's depth and against a programmable threshold. From this it derives an empty flag, a full flag and a threshold flag for each queue. These level flags are rebuilt on every clock and never latched. A small set of sticky event flags sits beside them. The event flags are set by pulses from the surrounding controller and cleared by writing ones to them.

A mask register selects which status bits may raise the interrupt line. A mask bit of one blocks its source. The interrupt line is a register. It changes only when the masked level it should carry differs from its present value. The queues themselves and the serial engine are outside this block. Configuration arrives through a narrow write port: a write enable, a 3-bit address and a data word.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the event bits are 0 and the interrupt line is 0. All three thresholds are 1 and every mask bit is 1. As a result, no status bit can raise the line until software clears its mask bit.
- R2: The status bit layout is:
  - Command queue: bit 0 is empty and bit 1 is full.
  - Receive queue: bit 3 is empty and bit 4 is full.
  - Transmit queue: bit 6 is empty and bit 7 is full.
  - Empty is 1 when the count is 0. Full is 1 when the count equals the queue depth (32, 64 and 64 by default).
  - Each level bit shows the count present before the previous clock edge, a latency of one cycle.
- R3: Status bit 2 is 1 when the command count is strictly less than the command threshold.
- R4: Status bit 5 is 1 when the receive count is greater than or equal to the receive threshold.
- R5: Status bit 8 is 1 when the transmit count is strictly less than the transmit threshold. A threshold of 0 keeps this bit at 0.
- R6: The level bits 0 to 8 are rebuilt on every cycle. A clear write to them has no effect.
- R7: Event bits 9 and up each latch a one-cycle pulse on the matching `evt_i` bit. A clear write with a one in that bit position clears it. When a pulse and a clear arrive in the same cycle, the bit stays set.
- R8: One cycle after the status word changes, `irq_o` equals the OR of the status bits whose mask bit is 0. A mask bit of 1 blocks its source.
- R9: Configuration writes take effect at the next clock edge. The addresses are:
  - 0: command threshold.
  - 1: receive threshold.
  - 2: transmit threshold.
  - 3: mask (low 11 bits).
  - 4: clear write.
  - Thresholds take the low 7 bits of the data word.
  - Writes to addresses 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_cnt_i | input | 6 | Fill count of the command queue |
| rx_cnt_i | input | 7 | Fill count of the receive queue |
| tx_cnt_i | input | 7 | Fill count of the transmit queue |
| evt_i | input | 2 | Event pulses that set the sticky status bits |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration write address |
| cfg_wdata_i | input | 16 | Configuration write data |
| status_o | output | 11 | Status word: event bits above the level bits |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets the exact threshold boundaries: a count one below, equal to and one above each threshold. A design that swapped `<` and `>=`, or used the wrong strictness, would flip bit 2, 5 or 8 at exactly one of these counts. The bench also covers:
- A transmit threshold of 0, which a sign or width slip would turn into an always-set bit.
- A pulse and a clear landing on the same event bit in the same cycle. A design that gave the clear priority would lose the event.
- Clear writes aimed at the level bits, and writes to the unused addresses. Here a faulty decode would disturb the status word or the mask.
- The state just after reset. A mask that did not reset to all ones would raise the line while no software has yet enabled a source.

// File: rtl/fiq_pkg.sv
package fiq_pkg;

  localparam int unsigned NQ        = 3;
  localparam int unsigned Q_GEN     = 0;
  localparam int unsigned Q_RX      = 1;
  localparam int unsigned Q_TX      = 2;
  localparam int unsigned BITS_PER_Q = 3;
  localparam int unsigned LVL_W     = NQ * BITS_PER_Q;

  // offsets of the per-queue flags inside a queue's 3-bit slice
  localparam int unsigned OFS_EMPTY = 0;
  localparam int unsigned OFS_FULL  = 1;
  localparam int unsigned OFS_THR   = 2;

  typedef enum logic [2:0] {
    CFG_GEN_THR = 3'd0,
    CFG_RX_THR  = 3'd1,
    CFG_TX_THR  = 3'd2,
    CFG_MASK    = 3'd3,
    CFG_CLEAR   = 3'd4
  } cfg_addr_e;

  // threshold comparison: receive side fires at or above, others below
  function automatic logic thr_hit(input int unsigned cnt,
                                   input int unsigned thr,
                                   input logic        at_or_above);
    if (at_or_above) return (cnt >= thr);
    return (cnt < thr);
  endfunction

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fiq_level_mon.sv
module fiq_level_mon #(
  parameter int unsigned DEPTH       = 32,
  parameter int unsigned CW          = 7,
  parameter bit          AT_OR_ABOVE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          thr_we_i,
  input  logic [CW-1:0] thr_d_i,
  output logic [CW-1:0] thr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          hit_o
);
  import fiq_pkg::*;

  localparam logic [CW-1:0] FULL_VAL = CW'(DEPTH);
  localparam logic [CW-1:0] THR_RST  = CW'(1);

  logic [CW-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= THR_RST;
    end else if (thr_we_i) begin
      thr_q <= thr_d_i;
    end
  end

  assign thr_o   = thr_q;
  assign empty_o = (cnt_i == '0);
  assign full_o  = (cnt_i == FULL_VAL);
  assign hit_o   = thr_hit(32'(cnt_i), 32'(thr_q), AT_OR_ABOVE);

endmodule

// File: rtl/fiq_event_bank.sv
module fiq_event_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ev_o
);
  logic [N-1:0] ev_q;

  // set has priority over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= '0;
    end else begin
      ev_q <= (ev_q & ~clr_i) | set_i;
    end
  end

  assign ev_o = ev_q;

endmodule

// File: rtl/fiq_irq_gate.sv
module fiq_irq_gate #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] mask_o,
  output logic         lvl_o,
  output logic         irq_o
);
  localparam logic [W-1:0] SRC_VALID = '1;

  logic [W-1:0] mask_q;
  logic         irq_q;
  logic         lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (mask_we_i) begin
      mask_q <= mask_d_i;
    end
  end

  assign lvl = |(status_i & ~mask_q & SRC_VALID);

  // pin register only moves when the computed level disagrees with it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (lvl != irq_q) begin
      irq_q <= lvl;
    end
  end

  assign mask_o = mask_q;
  assign lvl_o  = lvl;
  assign irq_o  = irq_q;

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl #(
  parameter int unsigned GEN_DEPTH = 32,
  parameter int unsigned RX_DEPTH  = 64,
  parameter int unsigned TX_DEPTH  = 64,
  parameter int unsigned N_EVT     = 2,
  parameter int unsigned CFG_W     = 16
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic [$clog2(GEN_DEPTH+1)-1:0]              gen_cnt_i,
  input  logic [$clog2(RX_DEPTH+1)-1:0]               rx_cnt_i,
  input  logic [$clog2(TX_DEPTH+1)-1:0]               tx_cnt_i,
  input  logic [N_EVT-1:0]                            evt_i,
  input  logic                                        cfg_we_i,
  input  logic [2:0]                                  cfg_addr_i,
  input  logic [CFG_W-1:0]                            cfg_wdata_i,
  output logic [fiq_pkg::LVL_W+N_EVT-1:0]             status_o,
  output logic                                        irq_o
);
  import fiq_pkg::*;

  localparam int unsigned GEN_CW = cnt_width(GEN_DEPTH);
  localparam int unsigned RX_CW  = cnt_width(RX_DEPTH);
  localparam int unsigned TX_CW  = cnt_width(TX_DEPTH);
  localparam int unsigned CW     = max3(GEN_CW, RX_CW, TX_CW);
  localparam int unsigned STAT_W = LVL_W + N_EVT;

  // named internal events, visible to the bound checker
  logic [NQ*CW-1:0] cnt_flat;
  logic [NQ*CW-1:0] thr_flat;
  logic [LVL_W-1:0] lvl_next;
  logic [LVL_W-1:0] lvl_q;
  logic [N_EVT-1:0] ev_w;
  logic [N_EVT-1:0] clr_evt_w;
  logic [STAT_W-1:0] status_w;
  logic [STAT_W-1:0] mask_w;
  logic              irq_lvl_w;
  logic              mask_we_w;
  logic              clear_we_w;

  assign cnt_flat[Q_GEN*CW +: CW] = CW'(gen_cnt_i);
  assign cnt_flat[Q_RX*CW  +: CW] = CW'(rx_cnt_i);
  assign cnt_flat[Q_TX*CW  +: CW] = CW'(tx_cnt_i);

  assign mask_we_w  = cfg_we_i && (cfg_addr_i == CFG_MASK);
  assign clear_we_w = cfg_we_i && (cfg_addr_i == CFG_CLEAR);

  // per-queue monitors; the receive queue compares at-or-above
  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam int unsigned DEPTH_Q = (q == Q_GEN) ? GEN_DEPTH :
                                      (q == Q_RX)  ? RX_DEPTH  : TX_DEPTH;
    localparam bit GE_Q = (q == Q_RX);

    logic thr_we;
    logic empty, full, hit;

    assign thr_we = cfg_we_i && (cfg_addr_i == 3'(q));

    fiq_level_mon #(
      .DEPTH       (DEPTH_Q),
      .CW          (CW),
      .AT_OR_ABOVE (GE_Q)
    ) u_mon (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_i    (cnt_flat[q*CW +: CW]),
      .thr_we_i (thr_we),
      .thr_d_i  (cfg_wdata_i[CW-1:0]),
      .thr_o    (thr_flat[q*CW +: CW]),
      .empty_o  (empty),
      .full_o   (full),
      .hit_o    (hit)
    );

    assign lvl_next[q*BITS_PER_Q + OFS_EMPTY] = empty;
    assign lvl_next[q*BITS_PER_Q + OFS_FULL]  = full;
    assign lvl_next[q*BITS_PER_Q + OFS_THR]   = hit;
  end

  // level bits are rebuilt every cycle, never held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_next;
    end
  end

  // clear writes only reach the sticky event bits
  assign clr_evt_w = clear_we_w ? cfg_wdata_i[STAT_W-1:LVL_W] : '0;

  fiq_event_bank #(
    .N (N_EVT)
  ) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr_evt_w),
    .ev_o   (ev_w)
  );

  assign status_w = {ev_w, lvl_q};

  fiq_irq_gate #(
    .W (STAT_W)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we_w),
    .mask_d_i  (cfg_wdata_i[STAT_W-1:0]),
    .status_i  (status_w),
    .mask_o    (mask_w),
    .lvl_o     (irq_lvl_w),
    .irq_o     (irq_o)
  );

  assign status_o = status_w;

endmodule

// File: rtl/fiq_chk.sv
module fiq_chk #(
  parameter int unsigned CW     = 7,
  parameter int unsigned LVL_W  = 9,
  parameter int unsigned N_EVT  = 2,
  parameter int unsigned STAT_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3*CW-1:0]   cnt_flat,
  input logic [3*CW-1:0]   thr_flat,
  input logic [N_EVT-1:0]  evt_i,
  input logic [N_EVT-1:0]  clr_evt_w,
  input logic [STAT_W-1:0] status_o,
  input logic [STAT_W-1:0] mask_w,
  input logic              irq_lvl_w,
  input logic              irq_o
);
  logic seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  // R1: first cycle out of reset has every source masked and the line low
  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> (mask_w == '1 && !irq_o && status_o[STAT_W-1:LVL_W] == '0));

  // R2: a queue is never both empty and full
  a_r2_gen_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[0] && status_o[1]));
  a_r2_rx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[3] && status_o[4]));
  a_r2_tx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[6] && status_o[7]));

  // R3
  a_r3_gen_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (status_o[2] == ($past(cnt_flat[0 +: CW]) < $past(thr_flat[0 +: CW]))));
  // R4
  a_r4_rx_at_or_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (status_o[5] == ($past(cnt_flat[CW +: CW]) >= $past(thr_flat[CW +: CW]))));
  // R5
  a_r5_tx_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (status_o[8] == ($past(cnt_flat[2*CW +: CW]) < $past(thr_flat[2*CW +: CW]))));

  // R7: a pulse always lands, an uncleared bit always holds
  a_r7_evt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> ((status_o[STAT_W-1:LVL_W] & $past(evt_i)) == $past(evt_i)));
  a_r7_evt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> ((status_o[STAT_W-1:LVL_W] & $past(status_o[STAT_W-1:LVL_W] & ~clr_evt_w))
              == $past(status_o[STAT_W-1:LVL_W] & ~clr_evt_w)));

  // R8: line follows the masked level one cycle later
  a_r8_irq_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (irq_o == $past(irq_lvl_w)));
  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && ($past(status_o & ~mask_w) == '0) |-> !irq_o);

endmodule

bind fifo_irq_ctrl fiq_chk #(
  .CW     (CW),
  .LVL_W  (fiq_pkg::LVL_W),
  .N_EVT  (N_EVT),
  .STAT_W (STAT_W)
) u_fiq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_flat  (cnt_flat),
  .thr_flat  (thr_flat),
  .evt_i     (evt_i),
  .clr_evt_w (clr_evt_w),
  .status_o  (status_o),
  .mask_w    (mask_w),
  .irq_lvl_w (irq_lvl_w),
  .irq_o     (irq_o)
);

// File: tb/fifo_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_tb_top;

  localparam int GDEP = 32, RDEP = 64, TDEP = 64;
  localparam int NEV = 2;
  localparam int SW = 11;
  localparam int THR_BITS = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] gen_cnt;
  logic [6:0] rx_cnt, tx_cnt;
  logic [NEV-1:0] evt;
  logic cfg_we;
  logic [2:0] cfg_addr;
  logic [15:0] cfg_wdata;
  logic [SW-1:0] status;
  logic irq;

  always #2 clk = ~clk;

  fifo_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .gen_cnt_i(gen_cnt), .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .evt_i(evt), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .status_o(status), .irq_o(irq)
  );

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit cmp_en = 0;

  // behavioural reference state
  int m_thr[3];
  int m_mask, m_ev, m_lvl, m_irq;

  function automatic int lvl_of(int g, int r, int t, int tg, int tr, int tt);
    int v = 0;
    if (g == 0)    v += 1;
    if (g == GDEP) v += 2;
    if (g < tg)    v += 4;
    if (r == 0)    v += 8;
    if (r == RDEP) v += 16;
    if (r >= tr)   v += 32;
    if (t == 0)    v += 64;
    if (t == TDEP) v += 128;
    if (t < tt)    v += 256;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr[0] <= 1; m_thr[1] <= 1; m_thr[2] <= 1;
      m_mask <= (1 << SW) - 1; m_ev <= 0; m_lvl <= 0; m_irq <= 0;
    end else begin
      m_lvl <= lvl_of(int'(gen_cnt), int'(rx_cnt), int'(tx_cnt), m_thr[0], m_thr[1], m_thr[2]);
      m_irq <= ((((m_ev << 9) | m_lvl) & ~m_mask & ((1 << SW) - 1)) != 0) ? 1 : 0;
      if (cfg_we && cfg_addr == 3'd4)
        m_ev <= (m_ev & ~int'(cfg_wdata[10:9])) | int'(evt);
      else
        m_ev <= m_ev | int'(evt);
      if (cfg_we) begin
        case (cfg_addr)
          3'd0, 3'd1, 3'd2: m_thr[cfg_addr] <= int'(cfg_wdata) % (1 << THR_BITS);
          3'd3: m_mask <= int'(cfg_wdata) % (1 << SW);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison, grouped by requirement
  always @(negedge clk) begin
    if (cmp_en) begin
      int st, ex;
      st = int'(status);
      ex = (m_ev << 9) | m_lvl;
      chk("R2 empty/full", st & 'h0DB, ex & 'h0DB);
      chk("R3 gen below", (st >> 2) & 1, (ex >> 2) & 1);
      chk("R4 rx at/above", (st >> 5) & 1, (ex >> 5) & 1);
      chk("R5 tx below", (st >> 8) & 1, (ex >> 8) & 1);
      chk("R7 events", st >> 9, m_ev);
      chk("R8 irq", int'(irq), m_irq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    step();
    cfg_we = 0;
  endtask

  initial begin
    rst_n = 0; gen_cnt = 0; rx_cnt = 0; tx_cnt = 0; evt = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    step(3);
    // R1: state held in reset
    chk("R1 status in reset", int'(status), 0);
    chk("R1 irq in reset", int'(irq), 0);
    cmp_en = 1;
    rst_n = 1;
    step(2);
    // R1: all empty, below-threshold flags set, line low because all masked
    chk("R1 status after reset", int'(status), 'h14D);
    chk("R1 masked irq", int'(irq), 0);

    // R9: unused address changes nothing (mask stays all ones)
    wr(7, 0); wr(5, 0); wr(6, 0);
    step(2);
    chk("R9 ignored address irq", int'(irq), 0);

    // R4 boundary: rx threshold 5, count 4/5/6, only bit 5 unmasked
    wr(3, ~(1 << 5) & 'h7FF);
    wr(1, 5);
    rx_cnt = 4; step(3);
    chk("R4 rx below thr", (int'(status) >> 5) & 1, 0);
    chk("R4 rx below thr irq", int'(irq), 0);
    rx_cnt = 5; step(1);
    chk("R4 rx equal thr bit", (int'(status) >> 5) & 1, 1);
    chk("R8 irq lags one cycle", int'(irq), 0);
    step(1);
    chk("R8 irq raised", int'(irq), 1);
    rx_cnt = 6; step(2);
    chk("R4 rx above thr", (int'(status) >> 5) & 1, 1);

    // R6: clear write to level bits has no effect
    wr(4, 'h1FF); step(1);
    chk("R6 level bits survive clear", int'(status) & 'h1FF,
        lvl_of(0, 6, 0, 1, 5, 1));

    // R3 boundary: gen threshold 3
    wr(0, 3);
    gen_cnt = 2; step(2);
    chk("R3 gen below thr", (int'(status) >> 2) & 1, 1);
    gen_cnt = 3; step(2);
    chk("R3 gen equal thr", (int'(status) >> 2) & 1, 0);

    // R5: tx threshold 0 never fires
    wr(2, 0); tx_cnt = 0; step(2);
    chk("R5 tx thr zero", (int'(status) >> 8) & 1, 0);
    wr(2, 9); tx_cnt = 8; step(2);
    chk("R5 tx below thr", (int'(status) >> 8) & 1, 1);
    tx_cnt = 9; step(2);
    chk("R5 tx equal thr", (int'(status) >> 8) & 1, 0);

    // R2: full counts
    gen_cnt = 6'(GDEP); rx_cnt = 7'(RDEP); tx_cnt = 7'(TDEP); step(2);
    chk("R2 all full", int'(status) & 'h0DB, 'h092);

    // R7: event latch, simultaneous set and clear
    wr(3, 'h7FF & ~('h3 << 9));
    evt = 2'b01; step(); evt = 0; step(2);
    chk("R7 event latched", int'(status) >> 9, 1);
    chk("R8 event irq", int'(irq), 1);
    evt = 2'b10; cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = 16'h0400;
    step(); evt = 0; cfg_we = 0; step(1);
    chk("R7 set wins over clear", int'(status) >> 9, 3);
    wr(4, 'h600); step(2);
    chk("R7 cleared", int'(status) >> 9, 0);
    chk("R8 irq dropped", int'(irq), 0);

    // random phase, reference compared every cycle
    for (int i = 0; i < 3000; i++) begin
      gen_cnt = 6'($urandom_range(0, GDEP));
      rx_cnt  = 7'($urandom_range(0, RDEP));
      tx_cnt  = 7'($urandom_range(0, TDEP));
      evt     = ($urandom_range(0, 7) == 0) ? NEV'($urandom) : '0;
      cfg_we  = ($urandom_range(0, 3) == 0);
      cfg_addr = 3'($urandom_range(0, 7));
      cfg_wdata = 16'($urandom);
      step();
    end
    cfg_we = 0; evt = 0;
    step(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule